// File: doc/BRIEF.md
# Per-Channel Linear Volume with Soft Mute

This block scales each channel of a time-multiplexed audio sample stream by its own linear gain, just before the noise-shaping modulator. Samples arrive one at a time as signed twos complement words with a strobe and a channel index. They leave one clock later, scaled, with the same strobe and index. Each channel has a 10-bit volume code and a mute bit, both held in an external control register file and presented to the block as static levels.

The gain actually applied is never switched in one step. Each channel keeps an applied gain register that moves toward the target set by its code and mute bit. The move happens only on that channel's own strobes, by at most a fixed increment per sample. A mute therefore fades the channel to silence over a bounded number of samples. Clearing the mute, or changing the code, glides the channel to the new level.

The gain equals (code + 1)/1024, with round-half-up and saturation to the sample width. Code 1023 is exact unity. Code 0 and a set mute bit both give a target of zero.

Top module: `vol_mute_top`

## Requirements
- R1: While reset is high, and on the first clock after it, `out_valid` is 0 and `out_data` is 0. Reset sets every applied gain to unity (1024/1024), so the first sample of any channel after reset leaves unchanged, even when that channel's mute bit is set.
- R2: With code 1023 and mute clear, once settled, the output equals the input bit for bit. This includes +FS (0x7FFFFF) and -FS (0x800000) at 24 bits.
- R3: Once settled, the output is floor((s*(code+1) + 512) / 1024), with s taken as a signed twos complement sample.
- R4: With a fixed positive input, the settled output rises strictly with the code.
- R5: On each strobe of a channel, its applied gain moves toward the target by at most STEP/1024 (STEP = 16). The output uses the gain held before that move.
- R6: After a channel's mute bit is set, its first strobe still uses the old gain. Starting from unity, the 65th strobe and every later one output exactly 0.
- R7: After the mute bit is cleared, the gain climbs back by the same increment, and from the 65th strobe on the output is at the programmed volume again.
- R8: A volume code of 0 ramps the channel to an output of exactly 0, as a mute does.
- R9: A channel's applied gain changes only on strobes that carry its own index. Strobes for other channels and idle cycles leave it unchanged.
- R10: `out_valid` is high exactly one clock after a cycle with `in_valid` high, and `out_ch` repeats that cycle's `in_ch`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_ch | input | 3 | Channel index of the incoming sample |
| in_data | input | 24 | Signed input sample |
| vol_code | input | 60 | Volume codes, channel c in bits [c*10 +: 10] |
| mute | input | 6 | Mute bit per channel, bit c for channel c |
| out_valid | output | 1 | Output strobe, one clock after `in_valid` |
| out_ch | output | 3 | Channel index of the output sample |
| out_data | output | 24 | Scaled signed output sample |

## Verification
The assertions assume that `in_ch` is below the channel count whenever `in_valid` is high. They also assume that codes and mute bits change only between strobes, never inside the clock edge that samples them. The bench drives every input on the falling clock edge and uses only channel indices 0 to 5. It changes a code or mute bit only between sample strobes, so the ramp checks see a stable target for the whole fade. Ramp lengths are checked against a bench-side gain model that steps by the same increment, so the exact output of every strobe during a fade is known.

// File: rtl/vol_pkg.sv
package vol_pkg;

    localparam int DEF_CHANNELS  = 6;
    localparam int DEF_SAMPLE_W  = 24;
    localparam int DEF_CODE_W    = 10;
    localparam int DEF_RAMP_STEP = 16;

    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_RISE = 2'd1,
        RAMP_FALL = 2'd2
    } ramp_dir_e;

    // Target gain in 1/2^CODE_W units: zero when muted or code is zero.
    function automatic int gain_target(input logic muted, input int code);
        int t;
        if (muted || code == 0) t = 0;
        else                    t = code + 1;
        return t;
    endfunction

    function automatic ramp_dir_e ramp_dir(input int cur, input int tgt);
        ramp_dir_e d;
        if (tgt > cur)      d = RAMP_RISE;
        else if (tgt < cur) d = RAMP_FALL;
        else                d = RAMP_HOLD;
        return d;
    endfunction

    // One bounded step of the applied gain toward its target.
    function automatic int ramp_next(input int cur, input int tgt, input int step);
        int n;
        case (ramp_dir(cur, tgt))
            RAMP_RISE: n = (tgt - cur > step) ? cur + step : tgt;
            RAMP_FALL: n = (cur - tgt > step) ? cur - step : tgt;
            default:   n = cur;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/vol_gain_ramp.sv
module vol_gain_ramp
    import vol_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W,
    parameter int STEP   = DEF_RAMP_STEP,
    localparam int GAIN_W = CODE_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic              muted,
    input  logic [CODE_W-1:0] code,
    output logic [GAIN_W-1:0] gain
);

    localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1 << CODE_W);

    logic [GAIN_W-1:0] tgt;
    logic [GAIN_W-1:0] nxt;
    ramp_dir_e         dir;

    always_comb begin
        tgt = GAIN_W'(gain_target(muted, int'(code)));
        dir = ramp_dir(int'(gain), int'(tgt));
        nxt = GAIN_W'(ramp_next(int'(gain), int'(tgt), STEP));
    end

    always_ff @(posedge clk) begin
        if (rst)         gain <= UNITY;
        else if (strobe) gain <= nxt;
    end

    // R5: one strobe moves the gain by no more than the ramp increment
    p_step_bound_r5: assert property (@(posedge clk) disable iff (rst)
        strobe |=> ((gain >= $past(gain)) ? int'(gain - $past(gain))
                                          : int'($past(gain) - gain)) <= STEP)
        else $error("gain step exceeds ramp increment");

    // R7: a rising target makes the gain climb on the next strobe
    p_rise_moves_r7: assert property (@(posedge clk) disable iff (rst)
        (strobe && dir == RAMP_RISE) |=> gain > $past(gain))
        else $error("gain failed to rise toward target");

    // R6: a falling target makes the gain drop on the next strobe
    p_fall_moves_r6: assert property (@(posedge clk) disable iff (rst)
        (strobe && dir == RAMP_FALL) |=> gain < $past(gain))
        else $error("gain failed to fall toward target");

    // R9: without its own strobe the gain holds
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(gain))
        else $error("gain moved without its strobe");

endmodule

// File: rtl/vol_scale.sv
module vol_scale
    import vol_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int CODE_W   = DEF_CODE_W,
    parameter int CH_W     = 3,
    localparam int GAIN_W  = CODE_W + 1,
    localparam int PROD_W  = SAMPLE_W + GAIN_W + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [CH_W-1:0]            in_ch,
    input  logic signed [SAMPLE_W-1:0] in_data,
    input  logic [GAIN_W-1:0]          gain,
    output logic                       out_valid,
    output logic [CH_W-1:0]            out_ch,
    output logic signed [SAMPLE_W-1:0] out_data
);

    typedef struct packed {
        logic                       valid;
        logic [CH_W-1:0]            ch;
        logic signed [SAMPLE_W-1:0] data;
    } beat_t;

    localparam logic signed [PROD_W-1:0] HALF  = PROD_W'(1 << (CODE_W - 1));
    localparam logic signed [PROD_W-1:0] MAX_S =
        {{(PROD_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
    localparam logic signed [PROD_W-1:0] MIN_S =
        {{(PROD_W-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};
    localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1 << CODE_W);

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;
    beat_t                    nxt_beat;
    beat_t                    beat_q;

    always_comb begin
        prod    = PROD_W'(in_data) * PROD_W'($signed({1'b0, gain}));
        shifted = (prod + HALF) >>> CODE_W;
        nxt_beat.valid = in_valid;
        nxt_beat.ch    = in_ch;
        if (shifted > MAX_S)      nxt_beat.data = MAX_S[SAMPLE_W-1:0];
        else if (shifted < MIN_S) nxt_beat.data = MIN_S[SAMPLE_W-1:0];
        else                      nxt_beat.data = shifted[SAMPLE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) beat_q <= '0;
        else     beat_q <= nxt_beat;
    end

    assign out_valid = beat_q.valid;
    assign out_ch    = beat_q.ch;
    assign out_data  = beat_q.data;

    // R2: a unity gain passes the sample through unchanged
    p_unity_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && gain == UNITY) |=> out_data == $past(in_data))
        else $error("unity gain altered the sample");

    // R6: a zero gain yields exact silence
    p_zero_floor_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && gain == '0) |=> out_data == '0)
        else $error("zero gain produced nonzero output");

endmodule

// File: rtl/vol_mute_top.sv
module vol_mute_top
    import vol_pkg::*;
#(
    parameter int NCH      = DEF_CHANNELS,
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int CODE_W   = DEF_CODE_W,
    parameter int STEP     = DEF_RAMP_STEP,
    localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int GAIN_W  = CODE_W + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [CH_W-1:0]            in_ch,
    input  logic signed [SAMPLE_W-1:0] in_data,
    input  logic [NCH*CODE_W-1:0]      vol_code,
    input  logic [NCH-1:0]             mute,
    output logic                       out_valid,
    output logic [CH_W-1:0]            out_ch,
    output logic signed [SAMPLE_W-1:0] out_data
);

    logic [GAIN_W-1:0] gains [NCH];
    logic [NCH-1:0]    strobe;
    logic [GAIN_W-1:0] gain_sel;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign strobe[c] = in_valid && (in_ch == CH_W'(c));

        vol_gain_ramp #(
            .CODE_W (CODE_W),
            .STEP   (STEP)
        ) u_ramp (
            .clk    (clk),
            .rst    (rst),
            .strobe (strobe[c]),
            .muted  (mute[c]),
            .code   (vol_code[c*CODE_W +: CODE_W]),
            .gain   (gains[c])
        );
    end

    always_comb begin
        gain_sel = gains[0];
        for (int c = 0; c < NCH; c++) begin
            if (in_ch == CH_W'(c)) gain_sel = gains[c];
        end
    end

    vol_scale #(
        .SAMPLE_W (SAMPLE_W),
        .CODE_W   (CODE_W),
        .CH_W     (CH_W)
    ) u_scale (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ch     (in_ch),
        .in_data   (in_data),
        .gain      (gain_sel),
        .out_valid (out_valid),
        .out_ch    (out_ch),
        .out_data  (out_data)
    );

    // R10: strobes only ever name an existing channel
    p_ch_range_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> int'(in_ch) < NCH)
        else $error("strobe with channel index out of range");

    // R9: at most one channel ramp advances per cycle
    p_one_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe))
        else $error("more than one channel strobed");

    // R10: the output strobe echoes the channel one clock later
    p_echo_ch_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid && out_ch == $past(in_ch)))
        else $error("output strobe or channel mismatch");

endmodule

// File: tb/vol_mute_top_bench.sv
module vol_mute_top_bench;

    localparam int NCH    = 6;
    localparam int SW     = 24;
    localparam int CW     = 10;
    localparam int STEP   = 16;
    localparam int CHW    = 3;
    localparam int FS     = 8388607;
    localparam int NFS    = -8388608;
    localparam int UNITY  = 1024;
    localparam int SETTLE = 70;
    localparam int RAMP   = 64;
    localparam int MAXJMP = 131073;

    localparam int NV = 8;
    localparam int T_CH   [NV] = '{0, 0, 1, 1, 4, 4, 5, 5};
    localparam int T_CODE [NV] = '{1023, 1023, 511, 511, 255, 1, 767, 767};
    localparam int T_IN   [NV] = '{8388607, -8388608, 1001, -1001, 4096, 8388607, -3, 1000};
    localparam int T_EXP  [NV] = '{8388607, -8388608, 501, -500, 1024, 16384, -2, 750};

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic [CHW-1:0]       in_ch = '0;
    logic signed [SW-1:0] in_data = '0;
    logic [NCH*CW-1:0]    vol_code = {NCH{10'd1023}};
    logic [NCH-1:0]       mute = '0;
    logic                 out_valid;
    logic [CHW-1:0]       out_ch;
    logic signed [SW-1:0] out_data;

    int errors = 0;
    int checks = 0;
    int route_bad = 0;
    int mg [NCH];
    int bcode [NCH];
    bit bmute [NCH];

    always #2 clk = ~clk;

    vol_mute_top u_vol_mute_top (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ch     (in_ch),
        .in_data   (in_data),
        .vol_code  (vol_code),
        .mute      (mute),
        .out_valid (out_valid),
        .out_ch    (out_ch),
        .out_data  (out_data)
    );

    function automatic int expect_out(input int s, input int g);
        longint p;
        p = longint'(s) * longint'(g) + 64'sd512;
        return int'(p >>> 10);
    endfunction

    function automatic int btarget(input int c);
        return (bmute[c] || bcode[c] == 0) ? 0 : bcode[c] + 1;
    endfunction

    function automatic int bnext(input int g, input int t);
        if (t > g) return (t - g > STEP) ? g + STEP : t;
        if (t < g) return (g - t > STEP) ? g - STEP : t;
        return g;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_code(input int c, input int code);
        bcode[c] = code;
        vol_code[c*CW +: CW] = CW'(code);
    endtask

    task automatic apply_mute(input int c, input bit m);
        bmute[c] = m;
        mute[c] = m;
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) mg[c] = UNITY;
    endtask

    // Drive one strobe at a falling edge; sample the result at the next one.
    task automatic send(input int c, input int s, output int y, output int e);
        in_valid = 1'b1;
        in_ch    = CHW'(c);
        in_data  = SW'(s);
        e = expect_out(s, mg[c]);
        @(negedge clk);
        y = int'(out_data);
        if (!out_valid || int'(out_ch) != c) route_bad++;
        mg[c] = bnext(mg[c], btarget(c));
        in_valid = 1'b0;
    endtask

    task automatic settle(input int c);
        int y, e;
        for (int k = 0; k < SETTLE; k++) send(c, 0, y, e);
    endtask

    initial begin
        #600000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int y, e, prev;
        bit mono_ok, jump_ok, exact_ok;
        for (int c = 0; c < NCH; c++) begin
            bcode[c] = 1023;
            bmute[c] = 1'b0;
        end
        model_reset();

        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
        check(out_data == '0, "R1 data in reset", out_data, 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
        send(3, 12345, y, e);
        check(y == 12345, "R1 unity after reset", y, 12345);

        // Vector table: R2 unity codes, R3 scaled codes
        for (int i = 0; i < NV; i++) begin
            apply_code(T_CH[i], T_CODE[i]);
            settle(T_CH[i]);
            send(T_CH[i], T_IN[i], y, e);
            check(y == T_EXP[i] && y == e, (T_CODE[i] == 1023) ? "R2 unity" : "R3 scale",
                  y, T_EXP[i]);
        end

        // R10: idle cycle gives no output strobe
        @(negedge clk);
        check(out_valid == 1'b0, "R10 idle no strobe", out_valid, 0);

        // R4: monotonic gain with code
        prev = -1;
        mono_ok = 1'b1;
        exact_ok = 1'b1;
        for (int i = 0; i < 16; i++) begin
            apply_code(3, 63 + 64 * i);
            settle(3);
            send(3, FS, y, e);
            if (y <= prev) mono_ok = 1'b0;
            if (y != e) exact_ok = 1'b0;
            prev = y;
        end
        check(mono_ok, "R4 strictly rising", prev, FS);
        check(exact_ok, "R4 settled values", prev, FS);
        check(prev == FS, "R2 top code after sweep", prev, FS);

        // R6/R5: mute fade on channel 2 from unity
        apply_mute(2, 1'b1);
        prev = FS;
        jump_ok = 1'b1;
        exact_ok = 1'b1;
        for (int k = 1; k <= SETTLE; k++) begin
            send(2, FS, y, e);
            if (k == 1) check(y == FS, "R6 first strobe keeps old gain", y, FS);
            if (k == RAMP + 1) check(y == 0, "R6 silent at strobe 65", y, 0);
            if (k == RAMP) check(y != 0, "R6 not silent before strobe 65", y, 1);
            if (y != e) exact_ok = 1'b0;
            if (prev - y > MAXJMP || y - prev > MAXJMP) jump_ok = 1'b0;
            prev = y;
        end
        check(jump_ok, "R5 fade step bound", prev, 0);
        check(exact_ok, "R5 fade follows increment", prev, 0);

        // R7: unmute ramps back to programmed volume
        apply_mute(2, 1'b0);
        prev = 0;
        jump_ok = 1'b1;
        exact_ok = 1'b1;
        for (int k = 1; k <= SETTLE; k++) begin
            send(2, FS, y, e);
            if (k == 1) check(y == 0, "R7 first strobe still silent", y, 0);
            if (k == RAMP + 1) check(y == FS, "R7 full level at strobe 65", y, FS);
            if (y != e) exact_ok = 1'b0;
            if (prev - y > MAXJMP || y - prev > MAXJMP) jump_ok = 1'b0;
            prev = y;
        end
        check(jump_ok, "R5 rise step bound", prev, FS);
        check(exact_ok, "R7 rise follows increment", prev, FS);

        // R8: code zero behaves as mute
        apply_code(3, 0);
        send(3, FS, y, e);
        check(y == FS, "R8 first strobe keeps old gain", y, FS);
        settle(3);
        send(3, FS, y, e);
        check(y == 0, "R8 code zero silent", y, 0);

        // R9: strobes on other channels do not advance a muted channel
        apply_mute(1, 1'b1);
        settle(0);
        repeat (5) @(negedge clk);
        send(1, 1000, y, e);
        check(y == 500, "R9 channel isolation", y, 500);
        apply_mute(1, 1'b0);

        // R1: reset mid-run restores unity even with mute held
        apply_mute(2, 1'b1);
        settle(2);
        send(2, FS, y, e);
        check(y == 0, "R6 muted before reset", y, 0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid during reset", out_valid, 0);
        rst = 1'b0;
        model_reset();
        send(2, NFS, y, e);
        check(y == NFS, "R1 unity after mid-run reset", y, NFS);

        // R10: every strobe came back on the next clock with its channel
        check(route_bad == 0, "R10 strobe and channel echo", route_bad, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule